// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command register of a byte-wide flash device. It watches bus writes. Each write is an address and a data byte, qualified by a one-cycle synchronous strobe and by the chip-enable, write-enable and output-enable levels. A program or erase starts only after an exact multi-write sequence. Both sequences open with a pair of unlock writes. Erase then needs a setup write and a second unlock pair before the final command.

When a sequence completes, the block sends a one-cycle start request to the embedded-algorithm sequencer that sits beside it. The request is either program, chip erase or sector erase. The target address, and the data byte for a program, are held on the operand outputs. Any write that does not fit the next expected step returns the decoder to read mode and discards the partial sequence. It also returns to read mode on reset and while the supply-low input is asserted. While the sequencer reports busy, bus writes are ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `readMode` is 1, all three start outputs are 0, and `opAddr` and `opData` are 0.
- R2: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, followed by any fourth write, produce the following:
  - `startProg` is high for exactly one cycle, in the cycle after the fourth write.
  - `opAddr` and `opData` hold the fourth write's full address and data.
  - The decoder is back in read mode.
- R3: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, then 0x10 to 0x5555, make `startChipErase` high for one cycle after the sixth write, and the decoder returns to read mode.
- R4: The same five writes followed by 0x30 to any address make `startSectorErase` high for one cycle. `opAddr` then holds that full 17-bit address.
- R5: Command-address matching uses only address bits 14:0. Bits 15 and 16 of an unlock, setup or erase-command write have no effect on decoding.
- R6: A write that does not match the expected address and data of the current step puts the decoder in read mode (`readMode`=1). The next write is then decoded as the first step of a new sequence.
- R7: A write of 0xF0 at any point in an unfinished unlock or erase sequence returns the decoder to read mode.
- R8: A write is accepted only when `wrValid`=1, `ceN`=0, `weN`=0 and `oeN`=1. A strobe with `oeN`=0, `ceN`=1 or `weN`=1 leaves the decoder state unchanged.
- R9: While `busy`=1, strobed writes are ignored and the partial-sequence state is kept. Once `busy` falls, the sequence continues from where it stood.
- R10: While `lowVcc`=1 the decoder is forced into read mode and every write is ignored.
- R11: At most one start output is high in any cycle. No start output is high in the cycle after `busy` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | One-cycle bus write strobe |
| ceN | input | 1 | Chip enable level, active low |
| weN | input | 1 | Write enable level, active low |
| oeN | input | 1 | Output enable level; must be high for a write |
| wrAddr | input | 17 | Write address |
| wrData | input | 8 | Write data |
| busy | input | 1 | Embedded algorithm in progress |
| lowVcc | input | 1 | Supply below lockout level |
| readMode | output | 1 | Decoder idle in read mode |
| startProg | output | 1 | One-cycle program start request |
| startChipErase | output | 1 | One-cycle chip erase start request |
| startSectorErase | output | 1 | One-cycle sector erase start request |
| opAddr | output | 17 | Latched program or sector address |
| opData | output | 8 | Latched program data |

## Verification
The bench builds the block with its default parameters. These are a 17-bit address, byte data, 15 matched address bits, and the two unlock addresses 0x5555 and 0x2AAA. With these values, writes that set bits 15 and 16 inside the unlock and erase steps are reachable, and the test can show that those bits do not affect decoding while still being latched as operand addresses. The same defaults let the bench use an address one off from an unlock address to hit the mismatch path at each step.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNLK1,
    ST_UNLK2,
    ST_PGM_SETUP,
    ST_ERS_SETUP,
    ST_ERS_UNLK1,
    ST_ERS_UNLK2
  } cmd_state_t;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic goProg;
    logic goChip;
    logic goSector;
  } cmd_strobe_t;

  localparam logic [7:0] CODE_UNLK_A  = 8'hAA;
  localparam logic [7:0] CODE_UNLK_B  = 8'h55;
  localparam logic [7:0] CODE_PGM     = 8'hA0;
  localparam logic [7:0] CODE_ERS     = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_RESET   = 8'hF0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int MATCH_W = 15,
  parameter logic [MATCH_W-1:0] UNLOCK_ADDR_A = 15'h5555,
  parameter logic [MATCH_W-1:0] UNLOCK_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              busy,
  input  logic              lowVcc,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cmd_strobe_t       strobe,
  output logic              readMode
);

  cmd_state_t state, nextState;
  logic accept, atA, atB;

  assign accept = wrValid & ~ceN & ~weN & oeN & ~busy & ~lowVcc;
  assign atA    = (wrAddr[MATCH_W-1:0] == UNLOCK_ADDR_A);
  assign atB    = (wrAddr[MATCH_W-1:0] == UNLOCK_ADDR_B);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (lowVcc) begin
      nextState = ST_READ;
    end else if (accept) begin
      nextState = ST_READ;
      unique case (state)
        ST_READ:
          if (atA && wrData == DATA_W'(CODE_UNLK_A)) nextState = ST_UNLK1;
        ST_UNLK1:
          if (atB && wrData == DATA_W'(CODE_UNLK_B)) nextState = ST_UNLK2;
        ST_UNLK2:
          if (atA && wrData == DATA_W'(CODE_PGM))      nextState = ST_PGM_SETUP;
          else if (atA && wrData == DATA_W'(CODE_ERS)) nextState = ST_ERS_SETUP;
        ST_PGM_SETUP: begin
          strobe.loadAddr = 1'b1;
          strobe.loadData = 1'b1;
          strobe.goProg   = 1'b1;
        end
        ST_ERS_SETUP:
          if (atA && wrData == DATA_W'(CODE_UNLK_A)) nextState = ST_ERS_UNLK1;
        ST_ERS_UNLK1:
          if (atB && wrData == DATA_W'(CODE_UNLK_B)) nextState = ST_ERS_UNLK2;
        ST_ERS_UNLK2:
          if (atA && wrData == DATA_W'(CODE_CHIP)) begin
            strobe.goChip = 1'b1;
          end else if (wrData == DATA_W'(CODE_SECTOR)) begin
            strobe.loadAddr = 1'b1;
            strobe.goSector = 1'b1;
          end
        default: nextState = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_READ;
    else       state <= nextState;
  end

  assign readMode = (state == ST_READ);

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_strobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              startProg,
  output logic              startChipErase,
  output logic              startSectorErase,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startProg        <= 1'b0;
      startChipErase   <= 1'b0;
      startSectorErase <= 1'b0;
      opAddr           <= '0;
      opData           <= '0;
    end else begin
      startProg        <= strobe.goProg;
      startChipErase   <= strobe.goChip;
      startSectorErase <= strobe.goSector;
      if (strobe.loadAddr) opAddr <= wrAddr;
      if (strobe.loadData) opData <= wrData;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int MATCH_W = 15,
  parameter logic [MATCH_W-1:0] UNLOCK_ADDR_A = 15'h5555,
  parameter logic [MATCH_W-1:0] UNLOCK_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              lowVcc,
  output logic              readMode,
  output logic              startProg,
  output logic              startChipErase,
  output logic              startSectorErase,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  cmd_strobe_t strobe;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W),
    .UNLOCK_ADDR_A(UNLOCK_ADDR_A), .UNLOCK_ADDR_B(UNLOCK_ADDR_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .ceN(ceN), .weN(weN),
    .oeN(oeN), .busy(busy), .lowVcc(lowVcc), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .readMode(readMode)
  );

  flash_cmd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .startProg(startProg), .startChipErase(startChipErase),
    .startSectorErase(startSectorErase), .opAddr(opAddr), .opData(opData)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              lowVcc,
  input logic              readMode,
  input logic              startProg,
  input logic              startChipErase,
  input logic              startSectorErase,
  input logic [ADDR_W-1:0] opAddr,
  input logic [DATA_W-1:0] opData
);

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startProg, startChipErase, startSectorErase})); // R11

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(startProg || startChipErase || startSectorErase)); // R11

  AST_LOWVCC_READ: assert property (@(posedge clk) disable iff (!rstN)
    lowVcc |=> readMode); // R10

  AST_PROG_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    startProg |-> (opData == $past(wrData) && opAddr == $past(wrAddr))); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startProg |=> !startProg); // R2

  AST_START_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (startChipErase || startSectorErase) |-> readMode); // R3

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (readMode && (oeN == 1'b0 || ceN == 1'b1 || weN == 1'b1)) |=> readMode); // R8

endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 24;

  // vector: {addr[16:0], data[7:0], start[1:0] (0 none,1 prog,2 chip,3 sector), readMode}
  localparam logic [27:0] VEC [N_VEC] = '{
    {17'h05555, 8'hAA, 2'd0, 1'b0}, // R2
    {17'h02AAA, 8'h55, 2'd0, 1'b0},
    {17'h05555, 8'hA0, 2'd0, 1'b0},
    {17'h1ABCD, 8'h3C, 2'd1, 1'b1},
    {17'h0D555, 8'hAA, 2'd0, 1'b0}, // R3 with A15 set (R5)
    {17'h0AAAA, 8'h55, 2'd0, 1'b0},
    {17'h15555, 8'h80, 2'd0, 1'b0},
    {17'h05555, 8'hAA, 2'd0, 1'b0},
    {17'h02AAA, 8'h55, 2'd0, 1'b0},
    {17'h05555, 8'h10, 2'd2, 1'b1},
    {17'h05555, 8'hAA, 2'd0, 1'b0}, // R4
    {17'h02AAA, 8'h55, 2'd0, 1'b0},
    {17'h05555, 8'h80, 2'd0, 1'b0},
    {17'h05555, 8'hAA, 2'd0, 1'b0},
    {17'h02AAA, 8'h55, 2'd0, 1'b0},
    {17'h14321, 8'h30, 2'd3, 1'b1},
    {17'h05555, 8'hAA, 2'd0, 1'b0}, // R6
    {17'h02AAB, 8'h55, 2'd0, 1'b1},
    {17'h02AAA, 8'h55, 2'd0, 1'b1},
    {17'h05555, 8'hAA, 2'd0, 1'b0}, // R7
    {17'h02AAA, 8'h55, 2'd0, 1'b0},
    {17'h00000, 8'hF0, 2'd0, 1'b1},
    {17'h15555, 8'hAA, 2'd0, 1'b0}, // R5 A16 in unlock
    {17'h00000, 8'hF0, 2'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [16:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        busy = 1'b0, lowVcc = 1'b0;
  logic        readMode, startProg, startChipErase, startSectorErase;
  logic [16:0] opAddr;
  logic [7:0]  opData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .ceN(ceN), .weN(weN),
    .oeN(oeN), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .lowVcc(lowVcc), .readMode(readMode), .startProg(startProg),
    .startChipErase(startChipErase), .startSectorErase(startSectorErase),
    .opAddr(opAddr), .opData(opData)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one strobed write; returns at the negedge after the capturing edge
  task automatic doWrite(input logic [16:0] a, input logic [7:0] d,
                         input logic c = 1'b0, input logic w = 1'b0, input logic o = 1'b1);
    @(negedge clk);
    wrAddr = a; wrData = d; ceN = c; weN = w; oeN = o; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  function automatic logic [2:0] starts();
    return {startSectorErase, startChipErase, startProg};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({readMode, starts(), opAddr, opData}, {1'b1, 3'b000, 17'h0, 8'h0}, "R1 reset state");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      logic [16:0] a;
      logic [7:0]  d;
      logic [1:0]  s;
      logic        rm;
      logic [2:0]  expS;
      {a, d, s, rm} = VEC[i];
      doWrite(a, d);
      expS = (s == 2'd0) ? 3'b000 : (3'b001 << (s - 2'd1));
      check(starts(), expS, $sformatf("R2/R3/R4 start vec %0d", i));
      check(readMode, rm, $sformatf("R6/R7 readMode vec %0d", i));
      if (s == 2'd1) check({opAddr, opData}, {a, d}, "R2 program operands");
      if (s == 2'd3) check(opAddr, a, "R4 sector address");
      if (s != 2'd0) begin
        @(negedge clk);
        check(starts(), 3'b000, "R11 single-cycle start pulse");
      end
    end

    // R8: blocked writes
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0);
    check(readMode, 1'b1, "R8 oeN low blocks write");
    doWrite(17'h05555, 8'hAA, 1'b1, 1'b0, 1'b1);
    check(readMode, 1'b1, "R8 ceN high blocks write");
    doWrite(17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1);
    check(readMode, 1'b1, "R8 weN high blocks write");

    // R9: busy ignores writes and holds state
    doWrite(17'h05555, 8'hAA);
    busy = 1'b1;
    doWrite(17'h00000, 8'hF0);
    check(readMode, 1'b0, "R9 busy write ignored, state kept");
    doWrite(17'h02AAA, 8'h55);
    busy = 1'b0;
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05555, 8'hA0);
    doWrite(17'h00123, 8'h5A);
    check(starts(), 3'b001, "R9 sequence resumes after busy");
    check({opAddr, opData}, {17'h00123, 8'h5A}, "R9 operands after busy");

    // R10: low supply
    doWrite(17'h05555, 8'hAA);
    check(readMode, 1'b0, "R10 setup unlock accepted");
    @(negedge clk); lowVcc = 1'b1;
    @(negedge clk);
    check(readMode, 1'b1, "R10 lowVcc forces read mode");
    doWrite(17'h05555, 8'hAA);
    check(readMode, 1'b1, "R10 write blocked during lowVcc");
    lowVcc = 1'b0;

    // R6: mismatch at erase second-unlock step
    doWrite(17'h05555, 8'hAA);
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05555, 8'h80);
    doWrite(17'h05555, 8'hAA);
    doWrite(17'h05555, 8'h55);
    check(readMode, 1'b1, "R6 mismatch in erase unlock");
    doWrite(17'h05555, 8'h10);
    check(starts(), 3'b000, "R6 no erase after mismatch");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule